// File: doc/BRIEF.md
# Fractional-N PLL Setting Calculator

This block turns a reference clock frequency and a wanted output clock frequency into the settings for a fractional-N PLL. The reference arrives in hertz and the target in units of 10 kHz. After one start pulse the block works out five values: the integer feedback multiplier, a post divider, an 18-bit fractional multiplier, a rounded sigma-delta factor and a bit that picks the oscillator's high range. The pre-divider is fixed and is reported on its own output.

All the division steps go through one shared restoring divider that produces one quotient bit per clock. The work is eight divisions in a fixed order. First the reference is scaled, then it is pre-divided, then come the multiplier, the integer part of the multiplier, the fraction, and three steps of the sigma-delta factor. Intermediate values are 48 bits wide. The caller pulses start with its operands valid and waits for the one-cycle done pulse. The results hold from one done pulse to the next.

Top module: `pll_param_calc`

## Requirements
- R1: After reset, busy, done and every result output are 0. The pre-divider output n_out always reads 16.
- R2: With S = clkin_hz / 10000 and REF = S / 16, m_out equals the low 12 bits of (target × M2) / REF. Every division truncates on unsigned values.
- R3: m2_out is 3 when bound_mode is 1 and target ≤ 65000. In every other case m2_out is 1.
- R4: mf_out equals the low 18 bits of (M2 × ((target − (M / M2) × REF) × 262144)) / REF, where M is the full quotient from R2.
- R5: dco_out is 1 exactly when target > 100000. Otherwise it is 0.
- R6: sd_out equals the low 8 bits of ((((M × S) / 10) / 4000) + 5) / 10.
- R7: done is high for exactly one cycle per accepted start. The result outputs change only in the cycle in which done is high.
- R8: A start pulse that arrives while busy is high is ignored. The running calculation finishes with its own operands.
- R9: busy rises in the cycle after an accepted start and stays high until the cycle in which done is high, when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to load the operands and begin a calculation |
| bound_mode | input | 1 | Allows the post divider of 3 for low targets |
| clkin_hz | input | 32 | Reference clock frequency in Hz |
| target | input | 32 | Wanted output frequency in 10 kHz units |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| n_out | output | 8 | Fixed pre-divider value |
| m_out | output | 12 | Integer multiplier |
| m2_out | output | 7 | Post divider |
| mf_out | output | 18 | Fractional multiplier |
| sd_out | output | 8 | Sigma-delta factor |
| dco_out | output | 1 | Oscillator high-range select |

## Verification
A wrong stored intermediate, such as the scaled clock, the pre-divided reference or the integer part, feeds later steps. It therefore spoils several outputs together, and the error appears at the very next done pulse. A sequencer that skips or repeats a step shifts the time of done and leaves the outputs moving outside done. The checker flags either case in the cycle it happens. A start that leaks in while the block is busy shows up as results computed from the second operand set.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

    localparam int CALC_W       = 48;
    localparam int HZ_PER_UNIT  = 10000;
    localparam int BOUND_LIMIT  = 65000;
    localparam int DCO_LIMIT    = 100000;
    localparam int SD_PRESCALE  = 10;
    localparam int SD_SCALE     = 250;
    localparam int SD_ROUND     = 5;
    localparam int SD_POST      = 10;
    localparam int M2_LOW       = 3;
    localparam int M2_DEFAULT   = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_SCALE,
        OP_REF,
        OP_MUL,
        OP_QUOT,
        OP_FRAC,
        OP_SDA,
        OP_SDB,
        OP_SDC
    } calc_op_e;

    typedef struct packed {
        logic [CALC_W-1:0] clk;
        logic [CALC_W-1:0] tgt;
        logic [CALC_W-1:0] m2;
        logic              dco;
    } calc_job_t;

    function automatic logic [CALC_W-1:0] pick_m2(input logic bound, input logic [CALC_W-1:0] tgt);
        if (bound && tgt <= CALC_W'(BOUND_LIMIT))
            return CALC_W'(M2_LOW);
        return CALC_W'(M2_DEFAULT);
    endfunction

    function automatic logic pick_dco(input logic [CALC_W-1:0] tgt);
        return tgt > CALC_W'(DCO_LIMIT);
    endfunction

endpackage

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    trial;
    logic [W-1:0]  diff;
    logic          fits;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        fits  = trial >= {1'b0, divisor};
        diff  = trial[W-1:0] - divisor;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= dividend;
                cnt_q <= CW'(W);
            end else if (cnt_q != '0) begin
                if (fits) begin
                    rem_q <= diff;
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                fin   <= (cnt_q == CW'(1));
            end
        end
    end

    assign quo = quo_q;

endmodule

// File: rtl/pll_calc_seq.sv
module pll_calc_seq
    import pll_calc_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int M_W    = 12,
    parameter int M2_W   = 7,
    parameter int FRAC_W = 18,
    parameter int SD_W   = 8,
    parameter int PRE_N  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bound_mode,
    input  logic [FREQ_W-1:0] clkin_hz,
    input  logic [FREQ_W-1:0] target,
    output logic              div_go,
    output logic [CALC_W-1:0] div_a,
    output logic [CALC_W-1:0] div_b,
    input  logic              div_fin,
    input  logic [CALC_W-1:0] div_quo,
    output logic              busy,
    output logic              done,
    output logic [M_W-1:0]    m_out,
    output logic [M2_W-1:0]   m2_out,
    output logic [FRAC_W-1:0] mf_out,
    output logic [SD_W-1:0]   sd_out,
    output logic              dco_out
);
    localparam logic [CALC_W-1:0] SD_DIV = CALC_W'(PRE_N * SD_SCALE);

    seq_state_e        state_q;
    calc_op_e          op_q;
    calc_job_t         job_q;
    logic [CALC_W-1:0] w_sclk;
    logic [CALC_W-1:0] w_ref;
    logic [CALC_W-1:0] w_m;
    logic [CALC_W-1:0] w_tmp;
    logic [FRAC_W-1:0] w_mf;
    logic [CALC_W-1:0] resid;

    always_comb begin
        resid = (job_q.tgt - w_tmp * w_ref) << FRAC_W;
        div_a = '0;
        div_b = CALC_W'(1);
        case (op_q)
            OP_SCALE: begin div_a = job_q.clk;             div_b = CALC_W'(HZ_PER_UNIT); end
            OP_REF:   begin div_a = w_sclk;                div_b = CALC_W'(PRE_N);       end
            OP_MUL:   begin div_a = job_q.tgt * job_q.m2;  div_b = w_ref;                end
            OP_QUOT:  begin div_a = w_m;                   div_b = job_q.m2;             end
            OP_FRAC:  begin div_a = job_q.m2 * resid;      div_b = w_ref;                end
            OP_SDA:   begin div_a = w_m * w_sclk;          div_b = CALC_W'(SD_PRESCALE); end
            OP_SDB:   begin div_a = w_tmp;                 div_b = SD_DIV;               end
            OP_SDC:   begin div_a = w_tmp + CALC_W'(SD_ROUND); div_b = CALC_W'(SD_POST); end
            default:  begin div_a = '0;                    div_b = CALC_W'(1);           end
        endcase
    end

    assign div_go = (state_q == ST_LAUNCH);
    assign busy   = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_SCALE;
            job_q   <= '0;
            w_sclk  <= '0;
            w_ref   <= '0;
            w_m     <= '0;
            w_tmp   <= '0;
            w_mf    <= '0;
            done    <= 1'b0;
            m_out   <= '0;
            m2_out  <= '0;
            mf_out  <= '0;
            sd_out  <= '0;
            dco_out <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        job_q.clk <= CALC_W'(clkin_hz);
                        job_q.tgt <= CALC_W'(target);
                        job_q.m2  <= pick_m2(bound_mode, CALC_W'(target));
                        job_q.dco <= pick_dco(CALC_W'(target));
                        op_q      <= OP_SCALE;
                        state_q   <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (div_fin) begin
                        case (op_q)
                            OP_SCALE: w_sclk <= div_quo;
                            OP_REF:   w_ref  <= div_quo;
                            OP_MUL:   w_m    <= div_quo;
                            OP_FRAC:  w_mf   <= div_quo[FRAC_W-1:0];
                            default:  w_tmp  <= div_quo;
                        endcase
                        if (op_q == OP_SDC) begin
                            m_out   <= w_m[M_W-1:0];
                            m2_out  <= job_q.m2[M2_W-1:0];
                            mf_out  <= w_mf;
                            sd_out  <= div_quo[SD_W-1:0];
                            dco_out <= job_q.dco;
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            op_q    <= calc_op_e'(op_q + 3'd1);
                            state_q <= ST_LAUNCH;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_param_calc.sv
module pll_param_calc
    import pll_calc_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int N_W    = 8,
    parameter int M_W    = 12,
    parameter int M2_W   = 7,
    parameter int FRAC_W = 18,
    parameter int SD_W   = 8,
    parameter int PRE_N  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bound_mode,
    input  logic [FREQ_W-1:0] clkin_hz,
    input  logic [FREQ_W-1:0] target,
    output logic              busy,
    output logic              done,
    output logic [N_W-1:0]    n_out,
    output logic [M_W-1:0]    m_out,
    output logic [M2_W-1:0]   m2_out,
    output logic [FRAC_W-1:0] mf_out,
    output logic [SD_W-1:0]   sd_out,
    output logic              dco_out
);
    logic              div_go;
    logic              div_fin;
    logic [CALC_W-1:0] div_a;
    logic [CALC_W-1:0] div_b;
    logic [CALC_W-1:0] div_quo;

    assign n_out = N_W'(PRE_N);

    pll_calc_seq #(
        .FREQ_W (FREQ_W),
        .M_W    (M_W),
        .M2_W   (M2_W),
        .FRAC_W (FRAC_W),
        .SD_W   (SD_W),
        .PRE_N  (PRE_N)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .bound_mode (bound_mode),
        .clkin_hz   (clkin_hz),
        .target     (target),
        .div_go     (div_go),
        .div_a      (div_a),
        .div_b      (div_b),
        .div_fin    (div_fin),
        .div_quo    (div_quo),
        .busy       (busy),
        .done       (done),
        .m_out      (m_out),
        .m2_out     (m2_out),
        .mf_out     (mf_out),
        .sd_out     (sd_out),
        .dco_out    (dco_out)
    );

    pll_restoring_div #(
        .W (CALC_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .fin      (div_fin),
        .quo      (div_quo)
    );

endmodule

// File: rtl/pll_calc_chk.sv
module pll_calc_chk #(
    parameter int M_W    = 12,
    parameter int M2_W   = 7,
    parameter int FRAC_W = 18,
    parameter int SD_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [M_W-1:0]    m_out,
    input logic [M2_W-1:0]   m2_out,
    input logic [FRAC_W-1:0] mf_out,
    input logic [SD_W-1:0]   sd_out,
    input logic              dco_out
);
    // R7: single-cycle completion pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: results move only together with done
    p_hold_results_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({m_out, m2_out, mf_out, sd_out, dco_out}));

    // R9: busy low when results are delivered
    p_idle_at_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: busy only begins after a start
    p_busy_from_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R8: a running job cannot be dropped or restarted without finishing
    p_no_abandon_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R3: post divider takes only its two legal values
    p_m2_legal_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (m2_out == M2_W'(1) || m2_out == M2_W'(3)));

    // R3/R5: low-band post divider never pairs with the high oscillator range
    p_m2_dco_r5: assert property (@(posedge clk) disable iff (rst)
        (done && m2_out == M2_W'(3)) |-> !dco_out);

endmodule

bind pll_param_calc pll_calc_chk #(
    .M_W    (M_W),
    .M2_W   (M2_W),
    .FRAC_W (FRAC_W),
    .SD_W   (SD_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .m_out   (m_out),
    .m2_out  (m2_out),
    .mf_out  (mf_out),
    .sd_out  (sd_out),
    .dco_out (dco_out)
);

// File: tb/tb_pll_param_calc.sv
`timescale 1ns/1ps
module tb_pll_param_calc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        bound_mode = 1'b0;
    logic [31:0] clkin_hz = '0;
    logic [31:0] target = '0;
    logic        busy, done, dco_out;
    logic [7:0]  n_out, sd_out;
    logic [11:0] m_out;
    logic [6:0]  m2_out;
    logic [17:0] mf_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pll_param_calc dut (
        .clk(clk), .rst(rst), .start(start), .bound_mode(bound_mode),
        .clkin_hz(clkin_hz), .target(target), .busy(busy), .done(done),
        .n_out(n_out), .m_out(m_out), .m2_out(m2_out), .mf_out(mf_out),
        .sd_out(sd_out), .dco_out(dco_out)
    );

    typedef struct {
        longint unsigned m, m2, mf, sd, dco;
    } exp_t;

    function automatic exp_t model(longint unsigned ck, longint unsigned t, bit bnd);
        exp_t e;
        longint unsigned sc, rf, mm, q, term;
        sc   = ck / 10000;
        rf   = sc / 16;
        e.m2 = (bnd && t <= 65000) ? 3 : 1;
        mm   = t * e.m2 / rf;
        q    = mm / e.m2;
        term = (t - q * rf) * 262144;
        e.mf = ((e.m2 * term) / rf) & 64'h3FFFF;
        e.sd = (((((mm * sc) / 10) / 4000) + 5) / 10) & 64'hFF;
        e.m  = mm & 64'hFFF;
        e.dco = (t > 100000) ? 1 : 0;
        return e;
    endfunction

    task automatic check(bit ok, string req, longint unsigned act, longint unsigned expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic launch(longint unsigned ck, longint unsigned t, bit bnd);
        @(negedge clk);
        clkin_hz = 32'(ck); target = 32'(t); bound_mode = bnd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_and_check(exp_t e);
        while (!done) @(negedge clk);
        check(m_out == 12'(e.m),    "R2 m_out",   m_out,   e.m);
        check(m2_out == 7'(e.m2),   "R3 m2_out",  m2_out,  e.m2);
        check(mf_out == 18'(e.mf),  "R4 mf_out",  mf_out,  e.mf);
        check(dco_out == e.dco[0],  "R5 dco_out", dco_out, e.dco);
        check(sd_out == 8'(e.sd),   "R6 sd_out",  sd_out,  e.sd);
        check(!busy,                "R9 busy at done", busy, 0);
        @(negedge clk);
        check(!done,                "R7 done width", done, 0);
    endtask

    task automatic run_job(longint unsigned ck, longint unsigned t, bit bnd);
        exp_t e;
        e = model(ck, t, bnd);
        launch(ck, t, bnd);
        check(busy, "R9 busy after start", busy, 1);
        finish_and_check(e);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        exp_t ea, eprev;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 flags", {busy, done}, 0);
        check(m_out == 0 && m2_out == 0 && mf_out == 0 && sd_out == 0 && !dco_out,
              "R1 results", m_out, 0);
        check(n_out == 8'd16, "R1 n_out", n_out, 16);

        // directed corners: R3 threshold, R5 threshold
        run_job(19_200_000, 65000, 1'b1);
        run_job(19_200_000, 65001, 1'b1);
        run_job(38_400_000, 100000, 1'b0);
        run_job(38_400_000, 100001, 1'b0);
        run_job(26_000_000, 27000, 1'b0);
        run_job(26_000_000, 27000, 1'b1);
        run_job(12_000_000, 3000, 1'b1);
        run_job(52_000_000, 297000, 1'b0);
        run_job(16_000_000, 16, 1'b0);

        // R8 start while busy is ignored; R7 outputs hold meanwhile
        eprev = model(52_000_000, 297000, 1'b0);
        eprev = model(16_000_000, 16, 1'b0);
        ea = model(27_000_000, 74250, 1'b1);
        launch(27_000_000, 74250, 1'b1);
        repeat (20) @(negedge clk);
        clkin_hz = 32'd40_000_000; target = 32'd150000; bound_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R8 still busy", busy, 1);
        check(m_out == 12'(eprev.m) && sd_out == 8'(eprev.sd), "R7 hold while busy", m_out, eprev.m);
        finish_and_check(ea);
        repeat (5) @(negedge clk);
        check(!busy && !done, "R8 no second run", {busy, done}, 0);

        // random operands
        for (int i = 0; i < 100; i++) begin
            longint unsigned ck, t;
            bit b;
            ck = 12_000_000 + ($urandom % 40_000_000);
            t  = 2500 + ($urandom % 250000);
            b  = $urandom % 2;
            if (i % 4 == 0) t = 2500 + ($urandom % 62500);
            run_job(ck, t, b);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule